// File: doc/BRIEF.md
# Serial Flash Status Register Guard

This block keeps the 16-bit status and control word of a serial flash device and rules on every decoded command strobe that wants to change it or to start an array operation. A command decoder upstream supplies one strobe per command: set-enable, clear-enable, status write with its 16-bit data word, page program, sector erase, block erase and whole-chip erase. The guard answers each strobe with a one-cycle accept or reject pulse. It updates the word, and on any accepted status write, program or erase it holds a busy flag for a fixed number of cycles.

Write protection for the word itself follows a 2-bit protection-mode field combined with the level of the active-low write-protect pin. The modes are: always writable, writable only while the pin is high, locked until the next power cycle, and locked for good. A whole-chip erase is refused unless the three low block-protect bits and the complement bit all agree. A power-cycle pulse clears the volatile bits and releases the power-cycle lock. The test reset `rst_n` clears everything. All interfaces are plain strobes and levels with no flow control, because every command resolves in one cycle. At most one strobe is expected per cycle; if several are high together, the order set-enable, clear-enable, status write, program, sector erase, block erase, chip erase picks one.

Top module: `flash_sr_guard`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `sr_out` is 0, `busy` is 0 and neither `cmd_acc` nor `cmd_rej` is high.
- R2: Bits 15, 13, 12 and 11 of `sr_out` always read 0. A status write loads only bits 14 (CMP), 10 (LB), 9 (QE), 8 (SRP1), 7 (SRP0) and 6..2 (BP4..BP0) from `wrsr_data`. Bit 1 (WEL) and bit 0 (WIP) are never taken from the data.
- R3: Every cycle with a strobe produces exactly one of `cmd_acc` or `cmd_rej` on the following cycle, and never both. A set-enable strobe sets WEL and a clear-enable strobe clears WEL, both accepted when not busy.
- R4: With WEL at 0, status write, program, sector erase, block erase and chip erase strobes are rejected and change nothing.
- R5: With SRP1:SRP0 = 00 and WEL = 1, a status write is accepted whatever the level of `wp_n`.
- R6: With SRP1:SRP0 = 01, a status write is rejected while `wp_n` is 0 and accepted while `wp_n` is 1, given WEL = 1.
- R7: With SRP1:SRP0 = 10, status writes are rejected. A `pwr_cycle` pulse sets SRP1:SRP0 to 00, clears WEL and WIP, and leaves the other loaded bits as they were.
- R8: With SRP1:SRP0 = 11, status writes are always rejected, and the field stays 11 across power cycles.
- R9: A chip erase with WEL = 1 is accepted only when bits 4, 3, 2 and 14 are all 0 or all 1.
- R10: An accepted status write, program or erase makes WIP (bit 0) and `busy` high from the next cycle for exactly BUSY_CYCLES cycles. At the end of that window WIP and WEL both return to 0.
- R11: While `busy` is high, every strobe is rejected and leaves the word unchanged.
- R12: Pulling `rst_n` low at any time clears every bit of the word, including the bits a power cycle keeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low test reset, clears all state |
| pwr_cycle | input | 1 | One-cycle power-cycle event |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_wren | input | 1 | Set-enable strobe |
| cmd_wrdi | input | 1 | Clear-enable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 16 | Data word for the status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Block erase strobe |
| cmd_ce | input | 1 | Chip erase strobe |
| sr_out | output | 16 | Current status and control word |
| cmd_acc | output | 1 | Strobe of the previous cycle was accepted |
| cmd_rej | output | 1 | Strobe of the previous cycle was rejected |
| busy | output | 1 | Operation in progress, equal to WIP |

## Verification
The bench builds the guard with BUSY_CYCLES set to 5 instead of the default 8. This keeps each busy window short, so random stimulus meets the start of a window, strobes inside it, and the final cycle where WIP and WEL clear together many times per run. Random status-write data rarely sets both protection bits at once, and periodic test resets bring the word back out of the permanent lock. With these choices all four protection modes and both chip-erase outcomes occur repeatedly next to the directed cases.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int SR_W   = 16;
  localparam int WIP_B  = 0;
  localparam int WEL_B  = 1;
  localparam int BP0_B  = 2;
  localparam int BP2_B  = 4;
  localparam int SRP0_B = 7;
  localparam int SRP1_B = 8;
  localparam int CMP_B  = 14;
  // bits a status write may load: CMP, LB, QE, SRP1, SRP0, BP4..BP0
  localparam logic [SR_W-1:0] WR_MASK = 16'h47FC;

  typedef enum logic [1:0] {
    PROT_SOFT = 2'b00,
    PROT_PIN  = 2'b01,
    PROT_LOCK = 2'b10,
    PROT_OTP  = 2'b11
  } prot_mode_e;
endpackage

// File: rtl/sr_lock_policy.sv
module sr_lock_policy
  import sr_pkg::*;
(
  input  prot_mode_e mode,
  input  logic       wp_n,
  output logic       writable
);
  always_comb begin
    unique case (mode)
      PROT_SOFT: writable = 1'b1;
      PROT_PIN:  writable = wp_n;
      default:   writable = 1'b0;
    endcase
  end
endmodule

// File: rtl/sr_erase_guard.sv
module sr_erase_guard (
  input  logic [2:0] bp_low,
  input  logic       cmp,
  output logic       ce_ok
);
  always_comb begin
    ce_ok = (bp_low == 3'b111 && cmp) || (bp_low == 3'b000 && !cmp);
  end
endmodule

// File: rtl/sr_busy_timer.sv
module sr_busy_timer #(
  parameter int BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (abort)           cnt_q <= '0;
    else if (start)           cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
  import sr_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_cycle,
  input  logic        wp_n,
  input  logic        cmd_wren,
  input  logic        cmd_wrdi,
  input  logic        cmd_wrsr,
  input  logic [15:0] wrsr_data,
  input  logic        cmd_pp,
  input  logic        cmd_se,
  input  logic        cmd_be,
  input  logic        cmd_ce,
  output logic [15:0] sr_out,
  output logic        cmd_acc,
  output logic        cmd_rej,
  output logic        busy
);
  logic [SR_W-1:0] nv_q;
  logic            wel_q;
  logic            acc_q, rej_q;
  logic            wip, op_done;
  logic            writable, ce_ok;
  prot_mode_e      mode;

  logic any_cmd, ok_c, start_c, wel_set, wel_clr, nv_wr;

  assign mode = prot_mode_e'(nv_q[SRP1_B:SRP0_B]);

  sr_lock_policy u_policy (
    .mode     (mode),
    .wp_n     (wp_n),
    .writable (writable)
  );

  sr_erase_guard u_ce (
    .bp_low (nv_q[BP2_B:BP0_B]),
    .cmp    (nv_q[CMP_B]),
    .ce_ok  (ce_ok)
  );

  sr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .abort (pwr_cycle),
    .start (start_c),
    .busy  (wip),
    .done  (op_done)
  );

  assign any_cmd = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp |
                   cmd_se | cmd_be | cmd_ce;

  // one decision per cycle, fixed priority among strobes
  always_comb begin
    ok_c    = 1'b0;
    start_c = 1'b0;
    wel_set = 1'b0;
    wel_clr = 1'b0;
    nv_wr   = 1'b0;
    if (!pwr_cycle && !wip) begin
      if (cmd_wren) begin
        ok_c = 1'b1; wel_set = 1'b1;
      end else if (cmd_wrdi) begin
        ok_c = 1'b1; wel_clr = 1'b1;
      end else if (cmd_wrsr) begin
        ok_c = wel_q && writable;
        nv_wr = ok_c;
        start_c = ok_c;
      end else if (cmd_pp || cmd_se || cmd_be) begin
        ok_c = wel_q;
        start_c = ok_c;
      end else if (cmd_ce) begin
        ok_c = wel_q && ce_ok;
        start_c = ok_c;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nv_q  <= '0;
      wel_q <= 1'b0;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
    end else if (pwr_cycle) begin
      wel_q <= 1'b0;
      acc_q <= 1'b0;
      rej_q <= 1'b0;
      if (mode == PROT_LOCK) nv_q[SRP1_B:SRP0_B] <= 2'b00;
    end else begin
      acc_q <= any_cmd && ok_c;
      rej_q <= any_cmd && !ok_c;
      if (nv_wr) nv_q <= wrsr_data & WR_MASK;
      if (op_done || wel_clr) wel_q <= 1'b0;
      else if (wel_set)       wel_q <= 1'b1;
    end
  end

  always_comb begin
    sr_out        = nv_q;
    sr_out[WEL_B] = wel_q;
    sr_out[WIP_B] = wip;
  end

  assign cmd_acc = acc_q;
  assign cmd_rej = rej_q;
  assign busy    = wip;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_out[15] == 1'b0 && sr_out[13:11] == 3'b000);

  // R3
  acc_rej_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_acc && cmd_rej));

  // R4
  wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |-> wel_q);

  // R11
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !pwr_cycle) |=> $stable(nv_q));

  // R7
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_cycle && sr_out[8:7] == 2'b10) |=> sr_out[8:7] == 2'b00);

  // R8
  otp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_out[8:7] == 2'b11) |=> sr_out[8:7] == 2'b11);
endmodule

// File: tb/test_flash_sr_guard.sv
module test_flash_sr_guard;
  localparam int BUSY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_cycle = 1'b0, wp_n = 1'b1;
  logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
  logic        cmd_pp = 1'b0, cmd_se = 1'b0, cmd_be = 1'b0, cmd_ce = 1'b0;
  logic [15:0] wrsr_data = '0;
  logic [15:0] sr_out;
  logic        cmd_acc, cmd_rej, busy;

  int checks = 0;
  int bad = 0;

  // bench model
  logic [15:0] m_nv;
  logic        m_wel, m_acc, m_rej;
  int          m_cnt;

  always #10 clk = ~clk;

  flash_sr_guard #(.BUSY_CYCLES(BUSY)) i_flash_sr_guard (
    .clk, .rst_n, .pwr_cycle, .wp_n, .cmd_wren, .cmd_wrdi, .cmd_wrsr,
    .wrsr_data, .cmd_pp, .cmd_se, .cmd_be, .cmd_ce,
    .sr_out, .cmd_acc, .cmd_rej, .busy
  );

  function automatic logic [15:0] exp_sr();
    logic [15:0] v;
    v = m_nv;
    v[1] = m_wel;
    v[0] = (m_cnt != 0);
    return v;
  endfunction

  function automatic logic may_write(logic [1:0] srp, logic wp);
    return (srp == 2'b00) || (srp == 2'b01 && wp);
  endfunction

  function automatic logic ce_uniform(logic [15:0] v);
    return (v[4:2] == 3'b111 && v[14]) || (v[4:2] == 3'b000 && !v[14]);
  endfunction

  task automatic model_clear();
    m_nv = '0; m_wel = 0; m_acc = 0; m_rej = 0; m_cnt = 0;
  endtask

  // k: 0 idle 1 wren 2 wrdi 3 wrsr 4 pp 5 se 6 be 7 ce 8 power cycle
  task automatic model_step(int k, logic [15:0] d, logic wp);
    logic ok;
    logic bsy;
    m_acc = 0; m_rej = 0;
    if (k == 8) begin
      m_wel = 0; m_cnt = 0;
      if (m_nv[8:7] == 2'b10) m_nv[8:7] = 2'b00;
      return;
    end
    bsy = (m_cnt != 0);
    if (m_cnt == 1) m_wel = 0;
    if (bsy) m_cnt = m_cnt - 1;
    if (k == 0) return;
    if (bsy) begin m_rej = 1; return; end
    ok = 0;
    case (k)
      1: begin ok = 1; m_wel = 1; end
      2: begin ok = 1; m_wel = 0; end
      3: begin
        ok = m_wel && may_write(m_nv[8:7], wp);
        if (ok) m_nv = d & 16'h47FC;
      end
      4, 5, 6: ok = m_wel;
      default: ok = m_wel && ce_uniform(m_nv);
    endcase
    if (ok && k >= 3) m_cnt = BUSY;
    m_acc = ok; m_rej = !ok;
  endtask

  task automatic compare(string tag);
    logic [15:0] e;
    e = exp_sr();
    checks++;
    if (sr_out !== e || cmd_acc !== m_acc || cmd_rej !== m_rej ||
        busy !== (m_cnt != 0)) begin
      bad++;
      $display("FAIL %s: sr=%h acc=%b rej=%b busy=%b expected sr=%h acc=%b rej=%b busy=%b",
               tag, sr_out, cmd_acc, cmd_rej, busy, e, m_acc, m_rej, m_cnt != 0);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cycle(int k, logic [15:0] d, logic wp, string tag);
    wp_n = wp; wrsr_data = d;
    cmd_wren = (k == 1); cmd_wrdi = (k == 2); cmd_wrsr = (k == 3);
    cmd_pp = (k == 4); cmd_se = (k == 5); cmd_be = (k == 6);
    cmd_ce = (k == 7); pwr_cycle = (k == 8);
    model_step(k, d, wp);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce, pwr_cycle} = '0;
    compare(tag);
  endtask

  task automatic drain(string tag);
    while (m_cnt != 0) cycle(0, '0, 1'b1, tag);
  endtask

  task automatic do_reset(string tag);
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    compare(tag);
    @(negedge clk);
    rst_n = 1'b1;
    cycle(0, '0, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset("R1 reset state");

    // R4 commands without WEL
    cycle(3, 16'h001C, 1'b1, "R4 wrsr without WEL");
    cycle(4, '0, 1'b1, "R4 pp without WEL");
    cycle(7, '0, 1'b1, "R4 ce without WEL");
    // R3 enable latch
    cycle(1, '0, 1'b1, "R3 wren");
    cycle(2, '0, 1'b1, "R3 wrdi");
    cycle(1, '0, 1'b0, "R3 wren again");
    // R5 + R2: write with pin low in soft mode, all ones except SRP1
    cycle(3, 16'hFEFF, 1'b0, "R5 R2 wrsr soft mode");
    cycle(1, '0, 1'b1, "R11 wren while busy");
    cycle(5, '0, 1'b1, "R11 se while busy");
    drain("R10 busy window");
    // R6 pin mode
    cycle(1, '0, 1'b0, "R6 wren");
    cycle(3, 16'h409C, 1'b0, "R6 wrsr pin low");
    cycle(3, 16'h409C, 1'b1, "R6 wrsr pin high");
    drain("R10 drain");
    // R9 chip erase
    cycle(1, '0, 1'b1, "R9 wren");
    cycle(7, '0, 1'b1, "R9 ce all ones");
    drain("R10 drain");
    cycle(1, '0, 1'b1, "R9 wren");
    cycle(3, 16'h0094, 1'b1, "R9 wrsr mixed bp");
    drain("R10 drain");
    cycle(1, '0, 1'b1, "R9 wren");
    cycle(7, '0, 1'b1, "R9 ce mixed rejected");
    cycle(3, 16'h0080, 1'b1, "R9 wrsr zeros");
    drain("R10 drain");
    cycle(1, '0, 1'b1, "R9 wren");
    cycle(7, '0, 1'b1, "R9 ce all zeros");
    drain("R10 drain");
    // R7 lockdown
    cycle(1, '0, 1'b1, "R7 wren");
    cycle(3, 16'h4108, 1'b1, "R7 enter lockdown");
    drain("R10 drain");
    cycle(1, '0, 1'b1, "R7 wren");
    cycle(3, 16'h0000, 1'b1, "R7 wrsr locked");
    cycle(8, '0, 1'b1, "R7 power cycle");
    cycle(1, '0, 1'b0, "R7 wren");
    cycle(3, 16'h0004, 1'b0, "R7 wrsr after release");
    cycle(8, '0, 1'b1, "R7 power cycle aborts busy");
    // R8 permanent lock
    cycle(1, '0, 1'b1, "R8 wren");
    cycle(3, 16'h0184, 1'b1, "R8 enter otp");
    drain("R10 drain");
    cycle(8, '0, 1'b1, "R8 power cycle");
    cycle(1, '0, 1'b1, "R8 wren");
    cycle(3, 16'h0000, 1'b1, "R8 wrsr rejected");
    // R12 test reset clears non-volatile bits
    do_reset("R12 reset clears otp");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [15:0] d;
      string tag;
      if (i % 300 == 299) begin
        do_reset("R12 periodic reset");
        continue;
      end
      k = $urandom_range(0, 11);
      if (k > 8) k = 1;
      d = 16'($urandom);
      if (d[8] && d[7] && ($urandom_range(0, 7) != 0)) d[8] = 1'b0;
      case (k)
        1, 2: tag = "R3 random enable";
        3: tag = "R6 random wrsr";
        7: tag = "R9 random ce";
        8: tag = "R7 random power";
        0: tag = "R10 random idle";
        default: tag = "R4 random op";
      endcase
      cycle(k, d, 1'($urandom_range(0, 1)), tag);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule